// File: doc/BRIEF.md
# Photon-Counting Pixel Matrix Back End

This block is the digital side of a matrix of photon-counting pixels. Each pixel receives two comparator flags: one set while the pulse is above a lower threshold, and one set while it is above an upper threshold. A pixel counts a pulse only when the pulse crosses the lower threshold and never reaches the upper one during that pulse. The count is recorded once, when the pulse falls back below the lower threshold.

Every pixel also has a test enable. A global test pulse reaches only the enabled pixels, where it acts like an in-window detector pulse. A synchronous clear zeroes all counters before an acquisition.

For readout, the same counter flip-flops become a shift register. All pixels are linked into one serial chain, so the whole matrix leaves through a single output pin, one bit per shift cycle. A mode input chooses between counting and shifting. The mode can only change on a clock edge while no shift is requested.

Top module: `pxc_matrix`

## Requirements
- R1: After reset, every counter is zero, the block is in count mode and `ser_o` is 0.
- R2: In count mode (`mode_i` = 0), a pulse on `above_lo_i` of a pixel during which `above_hi_i` stays low adds exactly one to that pixel's 12-bit counter. The count is taken after the pulse ends.
- R3: If `above_hi_i` is high in any cycle while `above_lo_i` is high, that pulse is not counted, even if `above_hi_i` falls before `above_lo_i` does.
- R4: `above_hi_i` pulses while `above_lo_i` is low do not change the counter.
- R5: A counter that holds 4095 stays at 4095 when another qualified pulse arrives. It does not wrap.
- R6: `test_pulse_i` acts as an in-window pulse only for pixels whose `test_en_i` bit is 1. Pixels with the bit at 0 ignore it.
- R7: In shift mode (`mode_i` = 1), each cycle with `shift_i` high moves the chain by one bit. The chain runs from pixel 0 up to pixel NPIX-1, and each counter shifts out MSB first. `ser_o` always shows the MSB of the last pixel, so the readout order is pixel NPIX-1 first, from bit 11 down to bit 0. Zeros enter at pixel 0, so a full readout leaves every counter at zero.
- R8: The registered mode follows `mode_i` only at clock edges where `shift_i` is low. While `shift_i` is high, changes on `mode_i` are ignored.
- R9: Pulses arriving in shift mode are not counted. `shift_i` high in count mode does not move any data.
- R10: `clear_i` high at a clock edge sets every counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 1 | Requested mode: 0 = count, 1 = shift |
| shift_i | input | 1 | Shift request; also holds the mode while high |
| clear_i | input | 1 | Synchronous clear of all counters |
| test_pulse_i | input | 1 | Global test pulse |
| test_en_i | input | N_COLS*N_ROWS | Per-pixel test enable |
| above_lo_i | input | N_COLS*N_ROWS | Per-pixel lower-threshold comparator flag |
| above_hi_i | input | N_COLS*N_ROWS | Per-pixel upper-threshold comparator flag |
| ser_o | output | 1 | Serial output of the chain (MSB of the last pixel) |

## Verification
The counters are visible only through the serial chain. A wrong increment, a missed veto or a wrapped counter therefore shows up at the next full readout, as a wrong 12-bit word at a known position in the bit stream. A broken link or a wrong shift direction moves bits across pixel boundaries, so every word after that point in the readout is wrong. A mode register that ignores the hold condition shows up as pulses that were counted or dropped against the expected count. This is visible in the readout that follows that phase.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_SHIFT = 1'b1
  } pxc_mode_e;
endpackage

// File: rtl/pxc_rst_sync.sv
module pxc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pxc_hit_qual.sv
module pxc_hit_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_i,
  input  logic hi_i,
  input  logic tp_i,
  input  logic tp_en_i,
  output logic hit_o
);
  logic lo_q, hi_q, busy_q, veto_q;
  logic lo_d, hi_d, busy_d, veto_d;

  always_comb begin
    lo_d   = lo_i | (tp_i & tp_en_i);
    hi_d   = hi_i;
    busy_d = lo_q;
    veto_d = lo_q ? (veto_q | hi_q) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      busy_q <= 1'b0;
      veto_q <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      busy_q <= busy_d;
      veto_q <= veto_d;
    end
  end

  assign hit_o = busy_q & ~lo_q & ~veto_q;

  // R2
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);

  // R3
  veto_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_q && hi_q) |=> !hit_o);
endmodule

// File: rtl/pxc_cell.sv
module pxc_cell
  import pxc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pxc_mode_e mode_i,
  input  logic      shift_i,
  input  logic      clear_i,
  input  logic      hit_i,
  input  logic      sin_i,
  output logic      sout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, inc_ok, do_shift;

  always_comb begin
    inc_ok   = (mode_i == MODE_COUNT) && hit_i && (cnt_q != CNT_MAX);
    do_shift = (mode_i == MODE_SHIFT) && shift_i;
    cnt_en   = clear_i | inc_ok | do_shift;
    if (clear_i)       cnt_d = '0;
    else if (do_shift) cnt_d = {cnt_q[CNT_W-2:0], sin_i};
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign sout_o = cnt_q[CNT_W-1];

  // R5
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clear_i && mode_i == MODE_COUNT) |=> cnt_q == CNT_MAX);

  // R10
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);

  // R9
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_COUNT && !hit_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pxc_matrix.sv
module pxc_matrix
  import pxc_pkg::*;
#(
  parameter int N_COLS = 50,
  parameter int N_ROWS = 52,
  parameter int CNT_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mode_i,
  input  logic                     shift_i,
  input  logic                     clear_i,
  input  logic                     test_pulse_i,
  input  logic [N_COLS*N_ROWS-1:0] test_en_i,
  input  logic [N_COLS*N_ROWS-1:0] above_lo_i,
  input  logic [N_COLS*N_ROWS-1:0] above_hi_i,
  output logic                     ser_o
);
  localparam int NPIX = N_COLS * N_ROWS;

  logic      rst_sn;
  pxc_mode_e mode_q, mode_d;
  logic      mode_en;
  logic [NPIX:0]   chain;
  logic [NPIX-1:0] hit;

  pxc_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sn)
  );

  always_comb begin
    mode_en = ~shift_i;
    mode_d  = mode_i ? MODE_SHIFT : MODE_COUNT;
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn)      mode_q <= MODE_COUNT;
    else if (mode_en) mode_q <= mode_d;
  end

  assign chain[0] = 1'b0;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    pxc_hit_qual u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_sn),
      .lo_i   (above_lo_i[p]),
      .hi_i   (above_hi_i[p]),
      .tp_i   (test_pulse_i),
      .tp_en_i(test_en_i[p]),
      .hit_o  (hit[p])
    );
    pxc_cell #(.CNT_W(CNT_W)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_sn),
      .mode_i (mode_q),
      .shift_i(shift_i),
      .clear_i(clear_i),
      .hit_i  (hit[p]),
      .sin_i  (chain[p]),
      .sout_o (chain[p+1])
    );
  end

  assign ser_o = chain[NPIX];

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    shift_i |=> $stable(mode_q));

  // R7
  shift_feed_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (mode_q == MODE_SHIFT && shift_i) |=> ser_o == $past(g_pix[NPIX-1].u_cell.cnt_q[CNT_W-2]));
endmodule

// File: tb/tb_pxc_matrix.sv
module tb_pxc_matrix;
  localparam int NC = 3;
  localparam int NR = 2;
  localparam int NP = NC * NR;
  localparam int W  = 12;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n, mode, shift, clear, tp;
  logic [NP-1:0] ten, lo, hi;
  logic ser;

  int checks = 0;
  int errors = 0;
  int expc [NP];
  bit counting;

  always #2 clk = ~clk;

  pxc_matrix #(.N_COLS(NC), .N_ROWS(NR), .CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .shift_i(shift),
    .clear_i(clear), .test_pulse_i(tp), .test_en_i(ten),
    .above_lo_i(lo), .above_hi_i(hi), .ser_o(ser)
  );

  function automatic int sat_inc(input int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [NP-1:0] l, input logic [NP-1:0] h, input logic t);
    @(negedge clk); lo = l; tp = t; hi = '0;
    @(negedge clk); hi = h;
    @(negedge clk); hi = '0;
    @(negedge clk); lo = '0; tp = 1'b0;
    repeat (2) @(negedge clk);
    if (counting)
      for (int p = 0; p < NP; p++)
        if ((l[p] || (t && ten[p])) && !h[p]) expc[p] = sat_inc(expc[p]);
  endtask

  task automatic readout(input string req);
    @(negedge clk); mode = 1'b1; shift = 1'b0;
    repeat (2) @(negedge clk);
    for (int p = NP - 1; p >= 0; p--) begin
      int v;
      v = 0;
      for (int b = 0; b < W; b++) begin
        v = (v << 1) | int'(ser);
        shift = 1'b1;
        @(negedge clk);
      end
      check(req, v, expc[p]);
    end
    shift = 1'b0; mode = 1'b0;
    repeat (2) @(negedge clk);
    for (int p = 0; p < NP; p++) expc[p] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode = 1'b0; shift = 1'b0; clear = 1'b0; tp = 1'b0;
    ten = '0; lo = '0; hi = '0; counting = 1'b1;
    for (int p = 0; p < NP; p++) expc[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 ser_o", int'(ser), 0);
    readout("R1 counters zero");

    // R2 clean pulses on pixel 2 only
    for (int i = 0; i < 5; i++) pulse(6'b000100, 6'b000000, 1'b0);
    // R3 vetoed pulses on pixel 1, R4 hi-only on pixel 0
    for (int i = 0; i < 3; i++) pulse(6'b000010, 6'b000010, 1'b0);
    for (int i = 0; i < 3; i++) pulse(6'b000000, 6'b000001, 1'b0);
    readout("R2 R3 R4 directed");

    // R6 test pulse on enabled pixels only
    ten = 6'b101001;
    for (int i = 0; i < 4; i++) pulse('0, '0, 1'b1);
    ten = '0;
    readout("R6 test enable");

    // random mix of kinds, R2 R3 R4 R6
    for (int i = 0; i < 60; i++) begin
      logic [NP-1:0] l, h;
      for (int p = 0; p < NP; p++) begin
        int k;
        k = $urandom % 4;
        l[p] = (k == 1) || (k == 2);
        h[p] = (k == 2) || (k == 3);
      end
      ten = NP'($urandom);
      pulse(l, h, ($urandom % 3) == 0);
    end
    ten = '0;
    readout("R2 R3 R4 R6 random");

    // R8 R9: shift_i high in count mode holds mode and moves nothing
    pulse(6'b111111, '0, 1'b0);
    @(negedge clk); shift = 1'b1; mode = 1'b1;
    pulse(6'b100001, '0, 1'b0);
    @(negedge clk); shift = 1'b0;
    readout("R8 R9 mode held");

    // R9: pulses in shift mode are not counted
    pulse(6'b010010, '0, 1'b0);
    @(negedge clk); mode = 1'b1;
    repeat (2) @(negedge clk);
    counting = 1'b0;
    pulse(6'b111111, '0, 1'b0);
    counting = 1'b1;
    readout("R9 shift mode ignores hits");

    // R10 clear
    for (int i = 0; i < 7; i++) pulse(NP'($urandom), '0, 1'b0);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    for (int p = 0; p < NP; p++) expc[p] = 0;
    readout("R10 clear");

    // R5 saturation on all pixels
    for (int i = 0; i < MAXV + 4; i++) pulse('1, '0, 1'b0);
    readout("R5 saturation");

    // R7 zeros filled in by the previous readout
    readout("R7 zero fill");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule